// File: doc/BRIEF.md
# Three-Wire Serial Nonvolatile Memory Model

This block is a synthesizable stand-in for a small serial nonvolatile memory that a host reaches over a select line, a serial clock, a serial input and a serial output. It samples the serial pins with its own system clock and acts on each rising edge of the serial clock while select is high. A frame opens with a start bit, carries a two-bit instruction code and a word address, and, for a write, a data word. Reads stream words continuously. Writes and erases run as a self-timed programming cycle. The host can poll that cycle by raising select and watching the serial output.

Write access is controlled by an enable flag. The flag is cleared at reset and whenever the supply-good input is low, so no programming can happen before the supply is declared good. A programming cycle starts only when select falls after a complete frame. Once started, it runs for a fixed number of system cycles whatever select does afterwards. The word array is held in ordinary registers and resets to the erased pattern.

Top module: `serial_nvm_model`

## Requirements
- R1: After reset the write enable flag is clear and every word reads as all ones. With select high and no frame begun, the output enable is 1 and the output shows 1 (ready).
- R2: With select low the output enable is 0. A partly received frame is dropped, and the next frame decodes from its start bit.
- R3: All fields are taken on rising serial clock edges while select is high. Input 0s before the start bit are skipped. The start bit is 1. Then come a 2-bit code, an ADDR_W-bit address and, for writes, a DATA_W-bit word, each most significant bit first.
- R4: Code 10 is a read. After its last address bit the output shows a single 0. Each following rising edge then presents the next data bit, MSB first. After the last bit of a word the address advances, wrapping from the top word to word 0.
- R5: Code 01 is a write. When select falls after all data bits and writing is enabled, the addressed word takes the data.
- R6: Code 11 is an erase. When select falls after the address and writing is enabled, the addressed word becomes all ones.
- R7: Code 00 with the two address MSBs equal to 11 sets write enable. Code 00 with those bits equal to 00 clears it. A write or erase with the flag clear leaves the array unchanged.
- R8: A frame ended by select falling before its last required bit has no effect.
- R9: A write or erase keeps the device busy for PROG_CYCLES system cycles. While busy and selected with no frame begun, the output shows 0, and it shows 1 afterwards. Select falling does not stop the cycle. Frames sent while busy are ignored.
- R10: While supply_ok is low the write enable flag is cleared and set-enable frames have no effect, so programming stays blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; serial pins are sampled on it |
| rst_n | input | 1 | Active-low power-on reset |
| supply_ok | input | 1 | High when the supply is good enough to program |
| sel | input | 1 | Device select, active high |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (read bits or ready status) |
| sdo_en | output | 1 | Output enable for sdo; 0 models high impedance |

## Verification
A wrong frame state shows up within the same frame. Either the dummy 0 of a read is missing, or the streamed bits come from the wrong word, and the scoreboard sees this on the first mismatching bit. A corrupted enable flag or command decode only surfaces on the next read-back of the target word, so every write, erase and blocked attempt is followed by a read. A broken programming timer shows as a ready status that appears too early or too late, which the bench measures in system cycles against PROG_CYCLES.

// File: rtl/snvm_pkg.sv
package snvm_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_OPC,
        ST_ADDR,
        ST_DATA,
        ST_READ,
        ST_DONE
    } fr_state_e;

    typedef enum logic [2:0] {
        CMD_NONE,
        CMD_WRITE,
        CMD_ERASE,
        CMD_WEN,
        CMD_WDIS
    } cmd_e;

    localparam logic [1:0] OP_READ  = 2'b10;
    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_ERASE = 2'b11;
    localparam logic [1:0] OP_EXT   = 2'b00;

endpackage

// File: rtl/snvm_prog_timer.sv
module snvm_prog_timer #(
    parameter int CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy
);
    localparam int CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (start) begin
            cnt_d = CW'(CYCLES);
        end else if (cnt_q != '0) begin
            cnt_d = cnt_q - CW'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign busy = (cnt_q != '0);

    // R9: a started cycle is visible as busy on the next edge
    assert_start_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        start |=> busy);

    // R9: busy cannot end while more than one cycle remains
    assert_busy_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && cnt_q > CW'(1)) |=> busy);

endmodule

// File: rtl/snvm_word_store.sv
module snvm_word_store #(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] waddr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ADDR_W-1:0] raddr,
    output logic [DATA_W-1:0] rdata
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] mem_d [DEPTH];
    logic [DATA_W-1:0] mem_q [DEPTH];

    always_comb begin
        mem_d = mem_q;
        if (we) mem_d[waddr] = wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '1;
        end else begin
            mem_q <= mem_d;
        end
    end

    assign rdata = mem_q[raddr];

endmodule

// File: rtl/snvm_frame.sv
module snvm_frame
    import snvm_pkg::*;
#(
    parameter int ADDR_W = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel,
    input  logic              sclk,
    input  logic              sdi,
    input  logic              busy,
    input  logic [DATA_W-1:0] rdata,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              cmd_v,
    output cmd_e              cmd_kind,
    output logic [ADDR_W-1:0] cmd_addr,
    output logic [DATA_W-1:0] cmd_data,
    output logic              sdo,
    output logic              sdo_en
);
    localparam int MAXF = (ADDR_W > DATA_W) ? ADDR_W : DATA_W;
    localparam int CNT_W = $clog2(MAXF + 1);

    typedef struct packed {
        fr_state_e         st;
        logic [CNT_W-1:0]  cnt;
        logic [1:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
        logic [ADDR_W-1:0] raddr;
        logic [DATA_W-1:0] rsh;
        logic [CNT_W-1:0]  rcnt;
        logic              dout;
        logic              sclk_prev;
        logic              sel_prev;
        logic              cmd_v;
        cmd_e              cmd;
    } fr_t;

    fr_t d, q;
    logic rise;
    logic [ADDR_W-1:0] addr_sh;

    function automatic cmd_e decode_cmd(input logic [1:0] op, input logic [ADDR_W-1:0] a);
        cmd_e c;
        c = CMD_NONE;
        case (op)
            OP_WRITE: c = CMD_WRITE;
            OP_ERASE: c = CMD_ERASE;
            OP_EXT: begin
                if (a[ADDR_W-1 -: 2] == 2'b11)      c = CMD_WEN;
                else if (a[ADDR_W-1 -: 2] == 2'b00) c = CMD_WDIS;
            end
            default: c = CMD_NONE;
        endcase
        return c;
    endfunction

    always_comb begin
        d           = q;
        d.sclk_prev = sclk;
        d.sel_prev  = sel;
        d.cmd_v     = 1'b0;
        d.cmd       = CMD_NONE;
        rise        = sel & sclk & ~q.sclk_prev;
        addr_sh     = {q.addr[ADDR_W-2:0], sdi};

        if (!sel) begin
            d.st = ST_IDLE;
            if (q.sel_prev && q.st == ST_DONE) begin
                d.cmd_v = 1'b1;
                d.cmd   = decode_cmd(q.op, q.addr);
            end
        end else if (rise) begin
            case (q.st)
                ST_IDLE: begin
                    if (sdi && !busy) begin
                        d.st  = ST_OPC;
                        d.cnt = '0;
                        d.op  = '0;
                    end
                end
                ST_OPC: begin
                    d.op = {q.op[0], sdi};
                    if (q.cnt == CNT_W'(1)) begin
                        d.st  = ST_ADDR;
                        d.cnt = '0;
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                ST_ADDR: begin
                    d.addr = addr_sh;
                    if (q.cnt == CNT_W'(ADDR_W - 1)) begin
                        d.cnt = '0;
                        if (q.op == OP_READ) begin
                            d.st    = ST_READ;
                            d.raddr = addr_sh;
                            d.rcnt  = '0;
                            d.dout  = 1'b0;
                        end else if (q.op == OP_WRITE) begin
                            d.st = ST_DATA;
                        end else begin
                            d.st = ST_DONE;
                        end
                    end else begin
                        d.cnt = q.cnt + CNT_W'(1);
                    end
                end
                ST_DATA: begin
                    d.data = {q.data[DATA_W-2:0], sdi};
                    if (q.cnt == CNT_W'(DATA_W - 1)) d.st = ST_DONE;
                    else                             d.cnt = q.cnt + CNT_W'(1);
                end
                ST_READ: begin
                    if (q.rcnt == '0) begin
                        d.dout = rdata[DATA_W-1];
                        d.rsh  = {rdata[DATA_W-2:0], 1'b0};
                    end else begin
                        d.dout = q.rsh[DATA_W-1];
                        d.rsh  = {q.rsh[DATA_W-2:0], 1'b0};
                    end
                    if (q.rcnt == CNT_W'(DATA_W - 1)) begin
                        d.rcnt  = '0;
                        d.raddr = q.raddr + ADDR_W'(1);
                    end else begin
                        d.rcnt = q.rcnt + CNT_W'(1);
                    end
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign rd_addr  = q.raddr;
    assign cmd_v    = q.cmd_v;
    assign cmd_kind = q.cmd;
    assign cmd_addr = q.addr;
    assign cmd_data = q.data;
    assign sdo_en   = sel & ((q.st == ST_IDLE) | (q.st == ST_READ));
    assign sdo      = (q.st == ST_READ) ? q.dout : ~busy;

    // R2: a deselected device is back at the wait-for-start point
    assert_deselect_idle_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> (q.st == ST_IDLE));

    // R8: commands only leave the decoder after select has dropped
    assert_cmd_after_drop_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_v |-> !$past(sel));

    // R4: the first read bit out is the dummy zero
    assert_read_dummy_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (q.st == ST_ADDR && d.st == ST_READ) |=> !sdo);

endmodule

// File: rtl/serial_nvm_model.sv
module serial_nvm_model
    import snvm_pkg::*;
#(
    parameter int ADDR_W      = 4,
    parameter int DATA_W      = 8,
    parameter int PROG_CYCLES = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic supply_ok,
    input  logic sel,
    input  logic sclk,
    input  logic sdi,
    output logic sdo,
    output logic sdo_en
);
    logic              busy;
    logic              prog_start;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] rdata;
    logic [ADDR_W-1:0] rd_addr;
    logic              cmd_v;
    cmd_e              cmd_kind;
    logic [ADDR_W-1:0] cmd_addr;
    logic [DATA_W-1:0] cmd_data;
    logic              wen_d, wen_q;

    snvm_frame #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_frame (
        .clk(clk), .rst_n(rst_n), .sel(sel), .sclk(sclk), .sdi(sdi),
        .busy(busy), .rdata(rdata), .rd_addr(rd_addr),
        .cmd_v(cmd_v), .cmd_kind(cmd_kind), .cmd_addr(cmd_addr),
        .cmd_data(cmd_data), .sdo(sdo), .sdo_en(sdo_en)
    );

    snvm_word_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk(clk), .rst_n(rst_n), .we(mem_we), .waddr(cmd_addr),
        .wdata(mem_wdata), .raddr(rd_addr), .rdata(rdata)
    );

    snvm_prog_timer #(.CYCLES(PROG_CYCLES)) u_timer (
        .clk(clk), .rst_n(rst_n), .start(prog_start), .busy(busy)
    );

    always_comb begin
        wen_d      = wen_q;
        mem_we     = 1'b0;
        prog_start = 1'b0;
        mem_wdata  = cmd_data;
        if (!supply_ok) begin
            wen_d = 1'b0;
        end else if (cmd_v && !busy) begin
            case (cmd_kind)
                CMD_WEN:  wen_d = 1'b1;
                CMD_WDIS: wen_d = 1'b0;
                CMD_WRITE: begin
                    mem_we     = wen_q;
                    prog_start = wen_q;
                end
                CMD_ERASE: begin
                    mem_we     = wen_q;
                    prog_start = wen_q;
                    mem_wdata  = '1;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) wen_q <= 1'b0;
        else        wen_q <= wen_d;
    end

    // R10: a low supply leaves the enable flag clear
    assert_supply_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !supply_ok |=> !wen_q);

    // R9: every array update is followed by a busy programming cycle
    assert_write_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |=> busy);

endmodule

// File: tb/tb_serial_nvm_model.sv
module tb_serial_nvm_model;
    localparam int AW   = 4;
    localparam int DW   = 8;
    localparam int PROG = 200;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic supply_ok = 1'b1;
    logic sel = 1'b0;
    logic sclk = 1'b0;
    logic sdi = 1'b0;
    logic sdo, sdo_en;

    int n_tests = 0;
    int n_fail  = 0;

    logic [DW-1:0] exp_mem [1 << AW];
    logic          wen_m = 1'b0;

    logic  exp_q[$];
    string mon_tag = "";
    event  mon_ev;

    always #2 clk = ~clk;

    serial_nvm_model #(.ADDR_W(AW), .DATA_W(DW), .PROG_CYCLES(PROG)) dut (
        .clk(clk), .rst_n(rst_n), .supply_ok(supply_ok), .sel(sel),
        .sclk(sclk), .sdi(sdi), .sdo(sdo), .sdo_en(sdo_en)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    // scoreboard monitor: pops one expected read bit per event
    always @(mon_ev) begin
        logic e;
        e = exp_q.pop_front();
        check({mon_tag, " sdo_en"}, int'(sdo_en), 1);
        check({mon_tag, " bit"}, int'(sdo), int'(e));
    end

    task automatic bit_out(input logic b);
        @(negedge clk); sdi = b; sclk = 1'b0;
        @(negedge clk); @(negedge clk);
        sclk = 1'b1;
        @(negedge clk); @(negedge clk);
    endtask

    task automatic select_dev();
        @(negedge clk); sel = 1'b1; sclk = 1'b0;
    endtask

    task automatic deselect_dev();
        @(negedge clk); sel = 1'b0; sclk = 1'b0;
        repeat (3) @(negedge clk);
    endtask

    task automatic send_head(input logic [1:0] op, input logic [AW-1:0] a);
        bit_out(1'b1);
        for (int i = 1; i >= 0; i--) bit_out(op[i]);
        for (int i = AW - 1; i >= 0; i--) bit_out(a[i]);
    endtask

    task automatic wait_ready(output int n);
        select_dev();
        n = 0;
        @(negedge clk);
        while (sdo !== 1'b1 && n < 2000) begin
            @(negedge clk);
            n++;
        end
        deselect_dev();
    endtask

    task automatic ext_cmd(input logic [1:0] top);
        select_dev();
        send_head(2'b00, {top, {(AW-2){1'b0}}});
        deselect_dev();
        if (supply_ok) wen_m = (top == 2'b11);
    endtask

    task automatic write_word(input logic [AW-1:0] a, input logic [DW-1:0] v, input int lead0);
        int n;
        select_dev();
        for (int i = 0; i < lead0; i++) bit_out(1'b0);
        send_head(2'b01, a);
        for (int i = DW - 1; i >= 0; i--) bit_out(v[i]);
        deselect_dev();
        if (wen_m && supply_ok) begin
            exp_mem[a] = v;
            wait_ready(n);
        end
    endtask

    task automatic erase_word(input logic [AW-1:0] a);
        int n;
        select_dev();
        send_head(2'b11, a);
        deselect_dev();
        if (wen_m && supply_ok) begin
            exp_mem[a] = '1;
            wait_ready(n);
        end
    endtask

    task automatic read_words(input string tag, input logic [AW-1:0] a, input int nw);
        logic [AW-1:0] ra;
        mon_tag = tag;
        select_dev();
        send_head(2'b10, a);
        exp_q.push_back(1'b0);
        -> mon_ev;
        @(negedge clk);
        ra = a;
        for (int w = 0; w < nw; w++) begin
            for (int b = DW - 1; b >= 0; b--) begin
                bit_out(1'b0);
                exp_q.push_back(exp_mem[ra][b]);
                -> mon_ev;
                @(negedge clk);
            end
            ra = ra + 1'b1;
        end
        deselect_dev();
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        n_tests++;
        $display("FAIL watchdog: actual timeout expected finish");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        int n;
        for (int i = 0; i < (1 << AW); i++) exp_mem[i] = '1;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);

        // R1: ready status on a fresh select, erased array
        select_dev();
        @(negedge clk);
        check("R1 idle sdo_en", int'(sdo_en), 1);
        check("R1 idle ready", int'(sdo), 1);
        deselect_dev();
        check("R2 deselected sdo_en", int'(sdo_en), 0);
        read_words("R1 R4 erased", 4'd0, 2);

        // R7: write with enable clear is ignored
        write_word(4'd3, 8'h5A, 0);
        read_words("R7 locked write", 4'd3, 1);

        // R5 R9: enabled write, busy then ready
        ext_cmd(2'b11);
        select_dev(); send_head(2'b01, 4'd3);
        for (int i = DW - 1; i >= 0; i--) bit_out(8'h5A >> i);
        deselect_dev();
        exp_mem[3] = 8'h5A;
        select_dev();
        @(negedge clk);
        check("R9 busy sdo_en", int'(sdo_en), 1);
        check("R9 busy status", int'(sdo), 0);
        n = 0;
        while (sdo !== 1'b1 && n < 2000) begin @(negedge clk); n++; end
        check("R9 duration in range", int'(n >= PROG - 20 && n <= PROG), 1);
        deselect_dev();
        read_words("R5 write readback", 4'd3, 1);

        // R3: leading zeros before start
        write_word(4'd4, 8'hC3, 2);
        write_word(4'd5, 8'h81, 0);
        read_words("R3 R4 sequential", 4'd3, 3);

        // R4: wrap from top word
        write_word(4'd15, 8'h3C, 0);
        read_words("R4 wrap", 4'd15, 2);

        // R6: erase
        erase_word(4'd4);
        read_words("R6 erase", 4'd4, 1);

        // R8: short frame, then R2 a fresh frame decodes
        select_dev(); send_head(2'b01, 4'd5);
        for (int i = DW - 1; i >= 1; i--) bit_out(1'b0);
        deselect_dev();
        select_dev();
        @(negedge clk);
        check("R8 no programming started", int'(sdo), 1);
        deselect_dev();
        read_words("R8 short frame", 4'd5, 1);

        // R2: deselect in the middle of a read
        select_dev(); send_head(2'b10, 4'd3);
        bit_out(1'b0);
        @(negedge clk); sel = 1'b0;
        @(negedge clk);
        check("R2 read cut sdo_en", int'(sdo_en), 0);
        deselect_dev();

        // R9: frame during busy ignored
        select_dev(); send_head(2'b01, 4'd6);
        for (int i = DW - 1; i >= 0; i--) bit_out(8'h11 >> i);
        deselect_dev();
        exp_mem[6] = 8'h11;
        select_dev(); send_head(2'b01, 4'd7);
        for (int i = DW - 1; i >= 0; i--) bit_out(8'h22 >> i);
        deselect_dev();
        wait_ready(n);
        read_words("R9 busy ignore", 4'd6, 2);

        // R7: disable blocks writes
        ext_cmd(2'b00);
        write_word(4'd3, 8'h00, 0);
        read_words("R7 after disable", 4'd3, 1);

        // R10: supply drop clears enable
        ext_cmd(2'b11);
        @(negedge clk); supply_ok = 1'b0;
        repeat (3) @(negedge clk);
        ext_cmd(2'b11);
        @(negedge clk); supply_ok = 1'b1;
        wen_m = 1'b0;
        write_word(4'd3, 8'h00, 0);
        read_words("R10 supply drop", 4'd3, 1);

        repeat (4) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule